// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target placed in front of a 4096-byte on-chip byte store. The store is modelled as a register array. A fast system clock oversamples the SCL and SDA lines. Both lines pass through two-flop synchronizers. Edge logic then finds START and STOP conditions and the SCL edges. A per-byte shifter receives data on rising SCL and presents data on falling SCL. The block never drives SDA high. It has only an active-high pull-down enable, so the pad can be built as open drain.

A write transaction carries a device-select byte, two address bytes and any number of data bytes. The data bytes go to consecutive locations. A read transaction streams bytes from an internal pointer for as long as the master acknowledges. The pointer is kept between transactions, so a read without an address phase continues where the last access stopped. When a write closes with STOP, a programmable busy window starts, counted in system clocks. During that window the block refuses its own device-select byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: While reset is held and on the first cycles after it, `sda_oe` is 0, so SDA is released.
- R2: Until a START has been seen, the block ignores the bus. A device-select byte clocked in without a preceding START gets no acknowledge.
- R3: A device-select byte is accepted when its upper four bits equal `SEL_PREFIX` (default 1010). Bits 3:1 are don't-care. Bit 0 sets the direction: 1 is read, 0 is write. On acceptance the block holds SDA low through the ninth SCL clock. On mismatch it stays silent until the next START or STOP.
- R4: After an accepted write select, the block acknowledges every received byte and stores each data byte in the byte store.
- R5: The two bytes that follow a write select form the address. The low nibble of the first byte gives address bits 11:8, and its upper nibble is ignored. The second byte gives bits 7:0. The pointer takes the new value only once the second byte is complete.
- R6: In a read, the block shifts out the byte at the pointer MSB first, one bit per SCL clock, and releases SDA on the ninth clock. If the master holds SDA low on that clock (ACK), the next byte follows.
- R7: The pointer advances by one for each byte stored or fetched and wraps from 4095 to 0. It persists across transactions. A read with no address phase starts at its current value.
- R8: When the master leaves SDA high on the ninth clock of a read byte (NACK), the block stops transmitting. It keeps SDA released until the next STOP or START.
- R9: After a STOP that ends a write holding at least one data byte, the block refuses its device-select byte for `TWR_CYCLES` system clocks. After the window it acknowledges again.
- R10: A START in the middle of a byte aborts that byte, leaves the pointer unchanged and restarts device-select matching.
- R11: `sda_oe` is raised only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A wrong internal state shows at the ports within one byte time. It appears as a missing or extra acknowledge on the ninth clock, or as a wrong bit in a read byte. A pointer that drifted, wrapped wrongly or was disturbed by an aborted byte shows on the next read without an address phase. The first byte returned then differs from the location the bus history predicts. A busy counter that runs too long or too short shows as an acknowledge given or refused on a select sent just after a write, and again on one sent just after the window.

// File: rtl/i2cmem_pkg.sv
`timescale 1ns/1ps
package i2cmem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_LOAD,
        ST_PARK
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } ph_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_d, scl_q, sda_d, sda_q;
    logic          scl_p, sda_p;

    always_comb begin
        scl_d = {scl_q[PW-2:0], scl_i};
        sda_d = {sda_q[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_p     = scl_q[STAGES];
    assign sda_p     = sda_q[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_byte_store.sv
`timescale 1ns/1ps
module i2c_byte_store #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
`timescale 1ns/1ps
module i2c_eeprom_target
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W      = 12,
    parameter logic [3:0] SEL_PREFIX  = 4'b1010,
    parameter int         TWR_CYCLES  = 1000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int                BUSY_W   = $clog2(TWR_CYCLES + 1);
    localparam logic [ADDR_W-1:0] PTR_ONE  = 1;
    localparam logic [BUSY_W-1:0] BUSY_ONE = 1;
    localparam logic [BUSY_W-1:0] BUSY_TOP = BUSY_W'(TWR_CYCLES);

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              wrote;
        logic [BUSY_W-1:0] busy;
        logic              oe;
    } state_t;

    state_t      d, q;
    logic        scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic        mem_we;
    logic [7:0]  rd_data;
    logic [15:0] addr_full;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(q.ptr),
        .wdata(q.sh),
        .raddr(q.ptr),
        .rdata(rd_data)
    );

    assign addr_full = {q.ahi, q.sh};

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (q.busy != '0) begin
            d.busy = q.busy - BUSY_ONE;
        end
        case (q.st)
            ST_RX: begin
                if (scl_rise && q.cnt != 4'd8) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall && q.cnt == 4'd8) begin
                    d.cnt = '0;
                    d.oe  = 1'b1;
                    d.st  = ST_ACK;
                    case (q.ph)
                        PH_DEV: begin
                            if (q.sh[7:4] == SEL_PREFIX && q.busy == '0) begin
                                d.rw = q.sh[0];
                                d.ph = PH_AHI;
                            end else begin
                                d.oe = 1'b0;
                                d.st = ST_PARK;
                            end
                        end
                        PH_AHI: begin
                            d.ahi = q.sh;
                            d.ph  = PH_ALO;
                        end
                        PH_ALO: begin
                            d.ptr = addr_full[ADDR_W-1:0];
                            d.ph  = PH_DATA;
                        end
                        default: begin
                            mem_we  = 1'b1;
                            d.ptr   = q.ptr + PTR_ONE;
                            d.wrote = 1'b1;
                        end
                    endcase
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    if (q.rw) begin
                        d.sh  = rd_data;
                        d.oe  = ~rd_data[7];
                        d.ptr = q.ptr + PTR_ONE;
                        d.st  = ST_TX;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_RX;
                    end
                end
            end
            ST_TX: begin
                if (scl_rise) begin
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall) begin
                    if (q.cnt == 4'd8) begin
                        d.oe = 1'b0;
                        d.st = ST_TX_ACK;
                    end else begin
                        d.oe = ~q.sh[3'd7 - q.cnt[2:0]];
                    end
                end
            end
            ST_TX_ACK: begin
                if (scl_rise) begin
                    d.st = sda_s ? ST_PARK : ST_TX_LOAD;
                end
            end
            ST_TX_LOAD: begin
                if (scl_fall) begin
                    d.sh  = rd_data;
                    d.oe  = ~rd_data[7];
                    d.ptr = q.ptr + PTR_ONE;
                    d.cnt = '0;
                    d.st  = ST_TX;
                end
            end
            default: ;
        endcase
        if (start_evt) begin
            d.st  = ST_RX;
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end
        if (stop_evt) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.wrote = 1'b0;
            if (q.wrote) begin
                d.busy = BUSY_TOP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    logic              parked_w;
    logic [BUSY_W-1:0] busy_w;
    assign parked_w = (q.st == ST_PARK);
    assign busy_w   = q.busy;
endmodule

// File: rtl/i2cmem_checker.sv
`timescale 1ns/1ps
module i2cmem_checker #(
    parameter int BUSY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              parked,
    input logic [BUSY_W-1:0] busy
);
    logic was_in_reset;

    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
    end

    always_ff @(posedge clk) begin
        if (was_in_reset === 1'b1) begin
            p_released_after_reset_r1: assert (!sda_oe)
                else $error("R1: SDA driven right after reset");
        end
    end

    p_drive_on_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s)
        else $error("R11: SDA pull-down raised while SCL high");

    p_parked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> !sda_oe)
        else $error("R8: SDA driven while parked");

    p_busy_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != '0) |=> (busy == $past(busy) - 1'b1))
        else $error("R9: write-cycle window not counting down");
endmodule

bind i2c_eeprom_target i2cmem_checker #(.BUSY_W(BUSY_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sda_oe(sda_oe),
    .scl_s (scl_s),
    .parked(parked_w),
    .busy  (busy_w)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
    localparam int Q   = 8;
    localparam int H   = 4;
    localparam int TWR = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    wire  sda_line = !(m_low || sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    int r11_viol = 0;
    logic [7:0]  model [4096];
    logic [11:0] mptr = '0;

    always #2.5 clk = ~clk;

    i2c_eeprom_target #(.TWR_CYCLES(TWR)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (m_scl),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && m_scl) r11_viol++;
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input bit b);
        tick(H); m_low = !b;
        tick(H); m_scl = 1'b1;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        tick(H); m_low = 1'b0;
        tick(H); m_scl = 1'b1;
        tick(H); acked = !sda_line;
        tick(H); m_scl = 1'b0;
    endtask

    task automatic rd_byte(input bit mack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H); m_low = 1'b0;
            tick(H); m_scl = 1'b1;
            tick(H); b = {b[6:0], sda_line};
            tick(H); m_scl = 1'b0;
        end
        tick(H); m_low = mack;
        tick(H); m_scl = 1'b1;
        tick(Q); m_scl = 1'b0;
    endtask

    function automatic logic [7:0] hi_byte(input logic [11:0] a);
        logic [3:0] junk;
        junk = 4'($urandom);
        return {junk, a[11:8]};
    endfunction

    task automatic send_addr(input logic [11:0] a, input string req);
        bit ack;
        wr_byte(8'hA0, ack); check(ack, "R3 write select", ack, 1);
        wr_byte(hi_byte(a), ack); check(ack, {req, " addr hi"}, ack, 1);
        wr_byte(a[7:0], ack); check(ack, {req, " addr lo"}, ack, 1);
    endtask

    task automatic do_write(input logic [11:0] a, input int n);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_addr(a, "R5");
        mptr = a;
        for (int i = 0; i < n; i++) begin
            v = 8'($urandom);
            model[mptr] = v;
            wr_byte(v, ack); check(ack, "R4 data ack", ack, 1);
            mptr = mptr + 12'd1;
        end
        bus_stop();
    endtask

    task automatic do_set_addr(input logic [11:0] a);
        bus_start();
        send_addr(a, "R5");
        bus_stop();
        mptr = a;
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, b);
            check(b == model[mptr], req, b, model[mptr]);
            mptr = mptr + 12'd1;
        end
    endtask

    task automatic do_read_cur(input int n, input string req);
        bit ack;
        bus_start();
        wr_byte(8'hA1, ack); check(ack, "R3 read select", ack, 1);
        read_bytes(n, req);
        bus_stop();
    endtask

    task automatic do_read_at(input logic [11:0] a, input int n);
        bit ack;
        bus_start();
        send_addr(a, "R5");
        mptr = a;
        bus_start();
        wr_byte(8'hA1, ack); check(ack, "R3 read select after restart", ack, 1);
        read_bytes(n, "R6 sequential data");
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        report();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        tick(5);
        check(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(3);
        check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R2: select byte without START
        m_scl = 1'b0; tick(Q);
        wr_byte(8'hA0, ack);
        check(!ack, "R2 no START no ack", ack, 0);
        m_low = 1'b0; tick(H); m_scl = 1'b1; tick(Q);

        // R3: wrong prefix refused, don't-care bits accepted
        bus_start();
        wr_byte(8'hB0, ack); check(!ack, "R3 prefix mismatch", ack, 0);
        bus_stop();
        bus_start();
        wr_byte(8'hAE, ack); check(ack, "R3 bits 3:1 ignored", ack, 1);
        bus_stop();

        // R4/R9: write then busy window
        do_write(12'h123, 3);
        bus_start();
        wr_byte(8'hA0, ack); check(!ack, "R9 busy refuses select", ack, 0);
        bus_stop();
        tick(TWR + 20);
        do_read_at(12'h123, 3);

        // R7: wrap and current-address read
        do_write(12'hFFE, 3);
        tick(TWR + 20);
        do_read_at(12'hFFE, 2);
        check(mptr == 12'h000, "R7 wrap expected", mptr, 0);
        do_read_cur(1, "R7 read continues at wrapped pointer");

        // R8: master NACK parks the block
        do_write(12'h200, 4);
        tick(TWR + 20);
        do_set_addr(12'h200);
        bus_start();
        wr_byte(8'hA1, ack); check(ack, "R3 read select", ack, 1);
        read_bytes(1, "R6 single byte");
        rd_byte(1'b0, b);
        check(b == 8'hFF, "R8 silent after NACK", b, 8'hFF);
        bus_stop();
        do_read_cur(1, "R7 pointer after NACK read");

        // R10: repeated START in mid-byte
        bus_start();
        wr_byte(8'hA0, ack); check(ack, "R10 first select", ack, 1);
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
        bus_start();
        wr_byte(8'hA1, ack); check(ack, "R10 select after restart", ack, 1);
        read_bytes(1, "R10 pointer unchanged by aborted byte");
        bus_stop();

        // random traffic
        for (int k = 0; k < 12; k++) begin
            logic [11:0] a;
            int n;
            a = 12'($urandom);
            n = 1 + int'($urandom % 4);
            do_write(a, n);
            tick(TWR + 20);
            do_read_at(a, n);
        end

        check(r11_viol == 0, "R11 drive raised only with SCL low", r11_viol, 0);
        report();
    end
endmodule